// File: doc/BRIEF.md
# Column Checksum Encoder and Verifier

This block adds checksum-based fault detection around a row-wise linear filter. The filter must apply the same constant response to every row. On the way into the filter, the encoder passes groups of complex rows through unchanged. It keeps a running sum for every column. After the last data row of a group it appends one extra row that holds those column sums, so the filter sees one row more than the group size.

On the way out of the filter, the verifier adds up the filtered data rows of each group column by column. It then compares each total with the filtered checksum row that follows them. Because the filter is linear, the two must agree apart from fixed-point rounding. The real and imaginary parts of every column are checked separately against a programmable tolerance. At the end of each group the verifier gives one verdict: a one-cycle done pulse and a pass/fail flag. It also reports the lowest failing column and pulses a recompute request, so the surrounding system can redo the group. The check has no meaning where the filter changes from row to row.

Both sides keep their column totals in a memory as deep as one row. They do one read-modify-write per accepted sample. Totals are widened by ceil(log2(group size + 1)) bits, so they cannot overflow.

Top module: `ccv_top`

## Requirements
- R1: The encoder outputs every accepted input sample in arrival order. Each one is sign-extended to the widened width and carries `enc_sum` = 0.
- R2: After every GROUP_ROWS input rows, the encoder emits exactly ROW_LEN checksum samples in column order 0 to ROW_LEN-1, each with `enc_sum` = 1. Each sample is the exact sum of that column's real parts and imaginary parts over the group, including at full-scale inputs. No input is accepted while the checksum row is being emitted.
- R3: The column sums start from zero in every group. Nothing from an earlier group leaks into a later one.
- R4: While `enc_valid` is high and `enc_ready` is low, the encoder output keeps its valid, data and `enc_sum` unchanged. No sample is lost or repeated under backpressure.
- R5: The verifier takes GROUP_ROWS data rows followed by one checksum row per group. Exactly one `vf_done` pulse, one cycle wide, goes out per group. It appears on the clock edge right after the edge that accepted the last checksum sample.
- R6: A column passes when |column sum − checksum| ≤ `tol` for the real part and for the imaginary part, each taken separately. A difference equal to `tol` passes. A difference of `tol`+1 in either part fails the group.
- R7: On a failing verdict, `vf_bad_col` holds the lowest failing column index. On a passing verdict it is 0. `vf_fail` and `vf_bad_col` stay unchanged until the next verdict.
- R8: `vf_redo` pulses together with `vf_done` exactly when the verdict is a failure, and at no other time.
- R9: While reset is high, and right after it, `enc_valid`, `vf_done`, `vf_fail` and `vf_redo` are 0 and `in_ready` is 1. `vf_ready` is 0 during reset and goes to 1 on the first clock edge after reset ends.
- R10: A failure in one group does not affect the verdict or the failing-column index of the next group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Raw sample offered to encoder |
| in_ready | output | 1 | Encoder accepts raw sample |
| in_re | input | DW | Raw sample, real part (signed) |
| in_im | input | DW | Raw sample, imaginary part (signed) |
| enc_valid | output | 1 | Encoded sample available |
| enc_ready | input | 1 | Downstream filter accepts encoded sample |
| enc_sum | output | 1 | Encoded sample belongs to the checksum row |
| enc_re | output | DW+GB | Encoded sample, real part (signed) |
| enc_im | output | DW+GB | Encoded sample, imaginary part (signed) |
| vf_valid | input | 1 | Filtered sample offered to verifier |
| vf_ready | output | 1 | Verifier accepts filtered sample |
| vf_re | input | VW | Filtered sample, real part (signed) |
| vf_im | input | VW | Filtered sample, imaginary part (signed) |
| tol | input | VW | Allowed absolute difference per part (unsigned) |
| vf_done | output | 1 | One-cycle verdict pulse |
| vf_fail | output | 1 | Verdict: group failed |
| vf_bad_col | output | log2(ROW_LEN) | Lowest failing column |
| vf_redo | output | 1 | Recompute request pulse |

## Verification
The bench drives full-scale groups, all at the most negative real value and the most positive imaginary value. A design that does not widen its sums enough would wrap them there. Three groups are sent back to back under random valid gaps and random backpressure. A design that failed to restart the sums would carry totals across groups, and one that mishandled the pause before the checksum row would drop or repeat samples. On the verifier side, the bench places a perturbation exactly at the tolerance and another one step beyond it. It also puts an error only in the imaginary part of a lower column while a larger real error sits in a higher column. This catches an off-by-one tolerance compare, a check that looks at the real part only, and a failing-column index that records the last failure instead of the first. A clean group after a failing one exposes a fail state that is not cleared.

// File: rtl/ccv_pkg.sv
package ccv_pkg;

  typedef enum logic {
    PH_DATA = 1'b0,
    PH_SUM  = 1'b1
  } enc_phase_e;

  // Extra accumulator bits so that a sum over `rows` samples never wraps.
  function automatic int grow_bits(input int rows);
    return $clog2(rows + 1);
  endfunction

endpackage

// File: rtl/ccv_acc_ram.sv
module ccv_acc_ram #(
  parameter int DEPTH = 1024,
  parameter int W     = 46,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/ccv_encoder.sv
module ccv_encoder import ccv_pkg::*; #(
  parameter int ROW_LEN    = 1024,
  parameter int GROUP_ROWS = 64,
  parameter int DW         = 16,
  localparam int GB        = grow_bits(GROUP_ROWS),
  localparam int AW        = DW + GB,
  localparam int CW        = $clog2(ROW_LEN),
  localparam int RW        = $clog2(GROUP_ROWS + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic signed [DW-1:0] in_re,
  input  logic signed [DW-1:0] in_im,
  output logic                 enc_valid,
  input  logic                 enc_ready,
  output logic                 enc_sum,
  output logic signed [AW-1:0] enc_re,
  output logic signed [AW-1:0] enc_im
);

  enc_phase_e      phase;
  logic [CW-1:0]   col;
  logic [RW-1:0]   row;
  logic            rd_pend;

  // second stage of the read-modify-write
  logic                 s_vld, s_first;
  logic [CW-1:0]        s_col;
  logic signed [DW-1:0] s_re, s_im;

  logic [2*AW-1:0]      rdata, wdata;
  logic signed [AW-1:0] rd_re, rd_im, x_re, x_im;
  logic                 take, slot_free, sum_issue, col_last, row_last;

  assign col_last  = (col == CW'(ROW_LEN - 1));
  assign row_last  = (row == RW'(GROUP_ROWS - 1));
  assign slot_free = !enc_valid || enc_ready;
  assign in_ready  = (phase == PH_DATA) && !rd_pend && slot_free;
  assign take      = in_valid && in_ready;
  assign sum_issue = (phase == PH_SUM) && !rd_pend && slot_free;

  assign rd_re = rdata[2*AW-1:AW];
  assign rd_im = rdata[AW-1:0];
  assign x_re  = {{GB{s_re[DW-1]}}, s_re};
  assign x_im  = {{GB{s_im[DW-1]}}, s_im};
  assign wdata = s_first ? {x_re, x_im} : {rd_re + x_re, rd_im + x_im};

  ccv_acc_ram #(.DEPTH(ROW_LEN), .W(2*AW)) u_acc (
    .clk   (clk),
    .we    (s_vld),
    .waddr (s_col),
    .wdata (wdata),
    .raddr (col),
    .rdata (rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_DATA;
      col       <= '0;
      row       <= '0;
      rd_pend   <= 1'b0;
      s_vld     <= 1'b0;
      s_first   <= 1'b0;
      s_col     <= '0;
      s_re      <= '0;
      s_im      <= '0;
      enc_valid <= 1'b0;
      enc_sum   <= 1'b0;
      enc_re    <= '0;
      enc_im    <= '0;
    end else begin
      s_vld   <= take;
      s_first <= (row == '0);
      s_col   <= col;
      s_re    <= in_re;
      s_im    <= in_im;
      rd_pend <= sum_issue;

      if (take) begin
        col <= col_last ? '0 : col + 1'b1;
        if (col_last) begin
          if (row_last) begin
            row   <= '0;
            phase <= PH_SUM;
          end else begin
            row <= row + 1'b1;
          end
        end
      end

      if (sum_issue) begin
        col <= col_last ? '0 : col + 1'b1;
        if (col_last) phase <= PH_DATA;
      end

      if (rd_pend) begin
        enc_valid <= 1'b1;
        enc_sum   <= 1'b1;
        enc_re    <= rd_re;
        enc_im    <= rd_im;
      end else if (take) begin
        enc_valid <= 1'b1;
        enc_sum   <= 1'b0;
        enc_re    <= {{GB{in_re[DW-1]}}, in_re};
        enc_im    <= {{GB{in_im[DW-1]}}, in_im};
      end else if (enc_ready) begin
        enc_valid <= 1'b0;
      end
    end
  end

  // R4: a stalled output sample is held unchanged
  assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
    enc_valid && !enc_ready |=> enc_valid && $stable(enc_re) && $stable(enc_im) && $stable(enc_sum));

  // R2: the first checksum sample of a row blocks new input
  assert_sum_blocks_input_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(enc_sum) |-> !in_ready);

endmodule

// File: rtl/ccv_verifier.sv
module ccv_verifier import ccv_pkg::*; #(
  parameter int ROW_LEN    = 1024,
  parameter int GROUP_ROWS = 64,
  parameter int VW         = 23,
  localparam int GB        = grow_bits(GROUP_ROWS),
  localparam int SW        = VW + GB,
  localparam int CW        = $clog2(ROW_LEN),
  localparam int RW        = $clog2(GROUP_ROWS + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 vf_valid,
  output logic                 vf_ready,
  input  logic signed [VW-1:0] vf_re,
  input  logic signed [VW-1:0] vf_im,
  input  logic        [VW-1:0] tol,
  output logic                 vf_done,
  output logic                 vf_fail,
  output logic [CW-1:0]        vf_bad_col,
  output logic                 vf_redo
);

  logic [CW-1:0] col;
  logic [RW-1:0] row;
  logic          take, col_last, row_chk;

  logic                 s_vld, s_first, s_chk, s_last;
  logic [CW-1:0]        s_col;
  logic signed [VW-1:0] s_re, s_im;

  logic [2*SW-1:0]      rdata, wdata;
  logic signed [SW-1:0] rd_re, rd_im, x_re, x_im;
  logic signed [SW:0]   d_re, d_im;
  logic        [SW:0]   a_re, a_im, tol_x;
  logic                 mis;

  logic          g_fail;
  logic [CW-1:0] g_col;

  assign take     = vf_valid && vf_ready;
  assign col_last = (col == CW'(ROW_LEN - 1));
  assign row_chk  = (row == RW'(GROUP_ROWS));

  assign rd_re = rdata[2*SW-1:SW];
  assign rd_im = rdata[SW-1:0];
  assign x_re  = {{GB{s_re[VW-1]}}, s_re};
  assign x_im  = {{GB{s_im[VW-1]}}, s_im};
  assign wdata = s_first ? {x_re, x_im} : {rd_re + x_re, rd_im + x_im};

  // compare path: real and imaginary parts judged separately
  assign d_re  = {rd_re[SW-1], rd_re} - {x_re[SW-1], x_re};
  assign d_im  = {rd_im[SW-1], rd_im} - {x_im[SW-1], x_im};
  assign a_re  = d_re[SW] ? $unsigned(-d_re) : $unsigned(d_re);
  assign a_im  = d_im[SW] ? $unsigned(-d_im) : $unsigned(d_im);
  assign tol_x = {{(GB+1){1'b0}}, tol};
  assign mis   = s_vld && s_chk && ((a_re > tol_x) || (a_im > tol_x));

  ccv_acc_ram #(.DEPTH(ROW_LEN), .W(2*SW)) u_acc (
    .clk   (clk),
    .we    (s_vld && !s_chk),
    .waddr (s_col),
    .wdata (wdata),
    .raddr (col),
    .rdata (rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      col        <= '0;
      row        <= '0;
      s_vld      <= 1'b0;
      s_first    <= 1'b0;
      s_chk      <= 1'b0;
      s_last     <= 1'b0;
      s_col      <= '0;
      s_re       <= '0;
      s_im       <= '0;
      g_fail     <= 1'b0;
      g_col      <= '0;
      vf_ready   <= 1'b0;
      vf_done    <= 1'b0;
      vf_fail    <= 1'b0;
      vf_bad_col <= '0;
      vf_redo    <= 1'b0;
    end else begin
      vf_ready <= 1'b1;
      vf_done  <= 1'b0;
      vf_redo  <= 1'b0;

      s_vld   <= take;
      s_first <= (row == '0);
      s_chk   <= row_chk;
      s_last  <= row_chk && col_last;
      s_col   <= col;
      s_re    <= vf_re;
      s_im    <= vf_im;

      if (take) begin
        col <= col_last ? '0 : col + 1'b1;
        if (col_last) row <= row_chk ? '0 : row + 1'b1;
      end

      if (mis && !g_fail) begin
        g_fail <= 1'b1;
        g_col  <= s_col;
      end

      if (s_vld && s_last) begin
        vf_done    <= 1'b1;
        vf_fail    <= g_fail || mis;
        vf_redo    <= g_fail || mis;
        vf_bad_col <= g_fail ? g_col : (mis ? s_col : '0);
        g_fail     <= 1'b0;
        g_col      <= '0;
      end
    end
  end

  // R5: the verdict strobe is a single-cycle pulse
  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    vf_done |=> !vf_done);

  // R8: recompute request only with a failing verdict
  assert_redo_with_fail_R8: assert property (@(posedge clk) disable iff (rst)
    vf_redo |-> vf_done && vf_fail);

  // R7: a passing verdict reports column zero
  assert_pass_col_zero_R7: assert property (@(posedge clk) disable iff (rst)
    vf_done && !vf_fail |-> vf_bad_col == '0);

  // R7: verdict fields hold between verdicts
  assert_verdict_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !vf_done |=> vf_done || ($stable(vf_fail) && $stable(vf_bad_col)));

endmodule

// File: rtl/ccv_top.sv
module ccv_top import ccv_pkg::*; #(
  parameter int ROW_LEN    = 1024,
  parameter int GROUP_ROWS = 64,
  parameter int DW         = 16,
  parameter int VW         = DW + grow_bits(GROUP_ROWS),
  localparam int EW        = DW + grow_bits(GROUP_ROWS),
  localparam int CW        = $clog2(ROW_LEN)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_re,
  input  logic [DW-1:0] in_im,
  output logic          enc_valid,
  input  logic          enc_ready,
  output logic          enc_sum,
  output logic [EW-1:0] enc_re,
  output logic [EW-1:0] enc_im,
  input  logic          vf_valid,
  output logic          vf_ready,
  input  logic [VW-1:0] vf_re,
  input  logic [VW-1:0] vf_im,
  input  logic [VW-1:0] tol,
  output logic          vf_done,
  output logic          vf_fail,
  output logic [CW-1:0] vf_bad_col,
  output logic          vf_redo
);

  ccv_encoder #(.ROW_LEN(ROW_LEN), .GROUP_ROWS(GROUP_ROWS), .DW(DW)) u_enc (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_re     (in_re),
    .in_im     (in_im),
    .enc_valid (enc_valid),
    .enc_ready (enc_ready),
    .enc_sum   (enc_sum),
    .enc_re    (enc_re),
    .enc_im    (enc_im)
  );

  ccv_verifier #(.ROW_LEN(ROW_LEN), .GROUP_ROWS(GROUP_ROWS), .VW(VW)) u_vf (
    .clk        (clk),
    .rst        (rst),
    .vf_valid   (vf_valid),
    .vf_ready   (vf_ready),
    .vf_re      (vf_re),
    .vf_im      (vf_im),
    .tol        (tol),
    .vf_done    (vf_done),
    .vf_fail    (vf_fail),
    .vf_bad_col (vf_bad_col),
    .vf_redo    (vf_redo)
  );

endmodule

// File: tb/sim_ccv_top.sv
`timescale 1ns/1ps
module sim_ccv_top;

  localparam int R  = 8;
  localparam int G  = 4;
  localparam int DW = 16;
  localparam int EW = DW + 3;
  localparam int VW = EW;
  localparam int NG = 3;
  localparam int NIN  = NG * G * R;
  localparam int NOUT = NG * (G + 1) * R;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, enc_ready = 1'b0, vf_valid = 1'b0;
  logic [DW-1:0] in_re = '0, in_im = '0;
  logic [VW-1:0] vf_re = '0, vf_im = '0, tol = '0;
  logic in_ready, enc_valid, enc_sum, vf_ready, vf_done, vf_fail, vf_redo;
  logic [EW-1:0] enc_re, enc_im;
  logic [2:0] vf_bad_col;

  ccv_top #(.ROW_LEN(R), .GROUP_ROWS(G), .DW(DW)) u0 (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_ready(in_ready), .in_re(in_re), .in_im(in_im),
    .enc_valid(enc_valid), .enc_ready(enc_ready), .enc_sum(enc_sum),
    .enc_re(enc_re), .enc_im(enc_im),
    .vf_valid(vf_valid), .vf_ready(vf_ready), .vf_re(vf_re), .vf_im(vf_im),
    .tol(tol), .vf_done(vf_done), .vf_fail(vf_fail),
    .vf_bad_col(vf_bad_col), .vf_redo(vf_redo)
  );

  always #10 clk = ~clk;

  int n_chk = 0, n_bad = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  initial begin
    wait (cyc >= 100000);
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  // encoder stimulus and expected stream
  int m_re[NIN], m_im[NIN];
  int e_re[NOUT], e_im[NOUT];
  bit e_sum[NOUT];
  int e_grp[NOUT];

  function automatic int rnd16();
    return int'($signed(16'($urandom)));
  endfunction

  function automatic void build_enc_expect();
    int o = 0;
    for (int g = 0; g < NG; g++) begin
      for (int i = 0; i < G * R; i++) begin
        e_re[o] = m_re[g*G*R + i]; e_im[o] = m_im[g*G*R + i];
        e_sum[o] = 1'b0; e_grp[o] = g; o++;
      end
      for (int c = 0; c < R; c++) begin
        int sr = 0, si = 0;
        for (int r = 0; r < G; r++) begin
          sr += m_re[g*G*R + r*R + c]; si += m_im[g*G*R + r*R + c];
        end
        e_re[o] = sr; e_im[o] = si; e_sum[o] = 1'b1; e_grp[o] = g; o++;
      end
    end
  endfunction

  // verifier matrix: G data rows then checksum row
  int v_re[(G+1)*R], v_im[(G+1)*R];

  function automatic void build_vf_clean();
    for (int c = 0; c < R; c++) begin
      int sr = 0, si = 0;
      for (int r = 0; r < G; r++) begin
        v_re[r*R + c] = rnd16(); v_im[r*R + c] = rnd16();
        sr += v_re[r*R + c]; si += v_im[r*R + c];
      end
      v_re[G*R + c] = sr; v_im[G*R + c] = si;
    end
  endfunction

  function automatic int absi(input int x);
    return (x < 0) ? -x : x;
  endfunction

  // expected verdict: first column beyond tolerance in either part, or -1
  function automatic int exp_bad_col(input int t);
    for (int c = 0; c < R; c++) begin
      int sr = 0, si = 0;
      for (int r = 0; r < G; r++) begin
        sr += v_re[r*R + c]; si += v_im[r*R + c];
      end
      if (absi(sr - v_re[G*R + c]) > t || absi(si - v_im[G*R + c]) > t) return c;
    end
    return -1;
  endfunction

  task automatic run_vf_group(input int t, input string req);
    int idx = 0, ebad;
    bit early = 1'b0;
    tol = VW'(t);
    ebad = exp_bad_col(t);
    while (idx < (G+1)*R) begin
      @(negedge clk);
      if (vf_done) early = 1'b1;
      if (($urandom % 3) == 0) vf_valid = 1'b0;
      else begin
        vf_valid = 1'b1;
        vf_re = VW'(v_re[idx]); vf_im = VW'(v_im[idx]);
        if (vf_ready) idx++;
      end
    end
    @(negedge clk);
    vf_valid = 1'b0;
    check(!early, {"R5 no early done ", req}, int'(early), 0);
    check(vf_done == 1'b0, {"R5 done not before next edge ", req}, int'(vf_done), 0);
    @(negedge clk);
    check(vf_done == 1'b1, {"R5 done pulse ", req}, int'(vf_done), 1);
    check(vf_fail == (ebad >= 0), {"R6 verdict ", req}, int'(vf_fail), int'(ebad >= 0));
    check(int'(vf_bad_col) == ((ebad >= 0) ? ebad : 0), {"R7 bad column ", req},
          int'(vf_bad_col), (ebad >= 0) ? ebad : 0);
    check(vf_redo == (ebad >= 0), {"R8 redo ", req}, int'(vf_redo), int'(ebad >= 0));
    @(negedge clk);
    check(vf_done == 1'b0 && vf_redo == 1'b0, {"R5 R8 pulse ends ", req},
          int'(vf_done) + int'(vf_redo), 0);
    check(vf_fail == (ebad >= 0), {"R7 verdict held ", req}, int'(vf_fail), int'(ebad >= 0));
  endtask

  initial begin
    int oi, ii, p_re, p_im;
    bit p_hold, p_sum;
    void'($urandom(32'h5a17));

    // reset state (R9)
    repeat (3) @(negedge clk);
    check(enc_valid == 1'b0, "R9 enc_valid in reset", int'(enc_valid), 0);
    check(in_ready == 1'b1, "R9 in_ready in reset", int'(in_ready), 1);
    check(vf_ready == 1'b0, "R9 vf_ready in reset", int'(vf_ready), 0);
    check(vf_done == 1'b0 && vf_fail == 1'b0 && vf_redo == 1'b0, "R9 verdict in reset",
          int'(vf_done) + int'(vf_fail) + int'(vf_redo), 0);
    rst = 1'b0;
    @(negedge clk);
    check(vf_ready == 1'b1, "R9 vf_ready after reset", int'(vf_ready), 1);
    check(vf_done == 1'b0 && vf_fail == 1'b0, "R9 verdict after reset",
          int'(vf_done) + int'(vf_fail), 0);

    // encoder: group 0 random, group 1 full scale, group 2 random
    for (int i = 0; i < NIN; i++) begin
      if (i / (G*R) == 1) begin m_re[i] = -32768; m_im[i] = 32767; end
      else begin m_re[i] = rnd16(); m_im[i] = rnd16(); end
    end
    build_enc_expect();
    oi = 0; ii = 0; p_hold = 1'b0; p_re = 0; p_im = 0; p_sum = 1'b0;
    while (oi < NOUT && cyc < 20000) begin
      @(negedge clk);
      if (p_hold)
        check(enc_valid && int'($signed(enc_re)) == p_re && int'($signed(enc_im)) == p_im
              && enc_sum == p_sum, "R4 stalled output held", int'($signed(enc_re)), p_re);
      enc_ready = (($urandom % 4) != 0);
      if (ii < NIN) begin
        in_valid = (($urandom % 4) != 0);
        in_re = DW'(m_re[ii]); in_im = DW'(m_im[ii]);
      end else in_valid = 1'b0;
      #1;
      p_hold = enc_valid && !enc_ready;
      p_re = int'($signed(enc_re)); p_im = int'($signed(enc_im)); p_sum = enc_sum;
      if (enc_valid && enc_ready) begin
        string rq;
        rq = !e_sum[oi] ? "R1 data passthrough" : (e_grp[oi] == 0 ? "R2 checksum" : "R3 checksum later group");
        check(int'($signed(enc_re)) == e_re[oi] && int'($signed(enc_im)) == e_im[oi],
              rq, int'($signed(enc_re)), e_re[oi]);
        check(enc_sum == e_sum[oi], {rq, " marker"}, int'(enc_sum), int'(e_sum[oi]));
        oi++;
      end
      if (in_valid && in_ready) ii++;
    end
    check(oi == NOUT && ii == NIN, "R4 all samples transferred", oi, NOUT);
    @(negedge clk);
    in_valid = 1'b0; enc_ready = 1'b1;

    // verifier cases
    build_vf_clean();
    run_vf_group(0, "clean tol 0");
    build_vf_clean();
    v_re[G*R + 5] += 3;
    run_vf_group(3, "diff equal tol");
    run_vf_group(2, "diff tol plus one");
    build_vf_clean();
    v_im[G*R + 2] -= 1;
    v_re[G*R + 6] += 10;
    run_vf_group(0, "imag-only first fail");
    build_vf_clean();
    run_vf_group(0, "R10 clean after fail");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule